// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the integer feedback divider of a frequency synthesizer loop. It divides its input clock by a requested integer N. A prescaler runs with two moduli, P and P+1, and a program counter and a swallow counter steer it. The block produces one output pulse, one input cycle wide, every N input cycles. A two-bit select picks the prescaler base modulus, 8 or 16. Each modulus has its own window of legal N.

The requested N is split as N = P·B + A, with A = N mod P and B = N div P. In each output period the prescaler runs for B segments. The first A segments last P+1 cycles and the rest last P cycles. A request that falls outside the legal window for the chosen modulus raises an error flag, and the divider goes on with the last legal setting. A change of N or of modulus is taken only at the end of the period in progress, so no output period is ever shortened or stretched. After reset the divider stays idle until a legal request is present. It starts counting on the first clock edge that sees one.

Top module: `pswallow_div`

## Requirements
- R1: Select codes 2'b00 and 2'b01 both choose base modulus 8. Codes 2'b10 and 2'b11 both choose base modulus 16. Each code is judged against the legal window of its own modulus.
- R2: With modulus 8, N is legal when N_MIN_LO ≤ N ≤ N_MAX_LO (defaults 201 and 16383). The block runs one period at the upper bound. `cfg_err` shows whether the request on the inputs at the previous rising edge was illegal (1) or legal (0).
- R3: With modulus 16, N is legal when N_MIN_HI ≤ N ≤ N_MAX_HI (defaults 521 and 32767). `cfg_err` has the same one-cycle timing as in R2.
- R4: While running with ratio N, `div_out` is high for exactly one input cycle in every N input cycles.
- R5: Every residue A from 0 to P−1 gives an exact period of N. This includes ratios that are a multiple of P and ratios one below a multiple of P.
- R6: An illegal request leaves the ratio in use unchanged. Output periods keep the last legal ratio.
- R7: A new legal request made mid-period does not change that period. The period completes at the old ratio and the next period uses the new one.
- R8: While `rst_n` is low, `div_out` and `cfg_err` are 0.
- R9: From reset until a legal request has been seen, `div_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sel | input | 2 | Modulus select: bit 1 = 0 gives 8, bit 1 = 1 gives 16 |
| n_req | input | NW | Requested division ratio N |
| div_out | output | 1 | One-cycle pulse per output period |
| cfg_err | output | 1 | Registered flag: request on the previous edge was illegal |

## Verification
The bench builds the block with the lower bounds reduced to 56 and 240. These are the smallest ratios for which the swallow count never exceeds the program count, and the upper bounds keep their defaults. With these values the bench can time every residue of both moduli, over 64 consecutive ratios each, in a short run, and alternate the two redundant select codes between neighbouring ratios. It also checks the error flag at both edges of each window, a full period at the largest modulus-8 ratio, a mid-period change and the hold on illegal requests.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } mod_sel_e;

  // Only the upper select bit matters; the lower bit is a redundant code.
  function automatic mod_sel_e decode_sel(input logic [1:0] code);
    return code[1] ? MOD_HI : MOD_LO;
  endfunction

endpackage

// File: rtl/pswallow_ratio.sv
module pswallow_ratio
  import pswallow_pkg::*;
#(
  parameter int NW       = 15,
  parameter int LOG_P_LO = 3,
  parameter int LOG_P_HI = 4,
  parameter int N_MIN_LO = 201,
  parameter int N_MAX_LO = 16383,
  parameter int N_MIN_HI = 521,
  parameter int N_MAX_HI = 32767,
  parameter int AW       = LOG_P_HI,
  parameter int BW       = NW - LOG_P_LO
) (
  input  logic [1:0]    sel,
  input  logic [NW-1:0] n_req,
  output logic          legal,
  output logic          hi,
  output logic [AW-1:0] a_cnt,
  output logic [BW-1:0] b_cnt
);

  localparam logic [NW-1:0] LO_MASK = NW'((1 << LOG_P_LO) - 1);
  localparam logic [NW-1:0] HI_MASK = NW'((1 << LOG_P_HI) - 1);

  mod_sel_e mode;
  int       n_int;

  always_comb begin
    mode  = decode_sel(sel);
    n_int = int'(n_req);
    if (mode == MOD_HI) begin
      hi    = 1'b1;
      legal = (n_int >= N_MIN_HI) && (n_int <= N_MAX_HI);
      a_cnt = AW'(n_req & HI_MASK);
      b_cnt = BW'(n_req >> LOG_P_HI);
    end else begin
      hi    = 1'b0;
      legal = (n_int >= N_MIN_LO) && (n_int <= N_MAX_LO);
      a_cnt = AW'(n_req & LO_MASK);
      b_cnt = BW'(n_req >> LOG_P_LO);
    end
  end

endmodule

// File: rtl/pswallow_presc.sv
module pswallow_presc #(
  parameter int CW      = 5,
  parameter int CNT_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  output logic          seg_end
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // next state
  always_comb begin
    cnt_d = cnt_q;
    if (reload) begin
      cnt_d = reload_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign seg_end = en && (cnt_q == '0);

  // a segment never lasts longer than the larger modulus plus one
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= CNT_MAX);

endmodule

// File: rtl/pswallow_ctl.sv
module pswallow_ctl #(
  parameter int LOG_P_LO = 3,
  parameter int LOG_P_HI = 4,
  parameter int AW       = 4,
  parameter int BW       = 12,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          legal,
  input  logic          new_hi,
  input  logic [AW-1:0] new_a,
  input  logic [BW-1:0] new_b,
  input  logic          seg_end,
  output logic          run,
  output logic          reload,
  output logic [CW-1:0] reload_val,
  output logic          pulse
);

  logic          run_q, run_d;
  logic [AW-1:0] sw_q, sw_d, sw_nx;
  logic [BW-1:0] pg_q, pg_d;
  logic          act_hi_q, act_hi_d;
  logic [AW-1:0] act_a_q, act_a_d;
  logic [BW-1:0] act_b_q, act_b_d;
  logic          term, start, take_new;
  logic          use_hi;
  logic [AW-1:0] use_a;
  logic [BW-1:0] use_b;

  // terminal value of the prescaler counter for one segment
  function automatic logic [CW-1:0] seg_last(input logic hi_m, input logic plus1);
    logic [CW-1:0] base;
    base = hi_m ? CW'(1 << LOG_P_HI) : CW'(1 << LOG_P_LO);
    return plus1 ? base : base - 1'b1;
  endfunction

  // next state
  always_comb begin
    term     = run_q && seg_end && (pg_q == '0);
    start    = (!run_q && legal) || term;
    take_new = start && legal;

    use_hi = take_new ? new_hi : act_hi_q;
    use_a  = take_new ? new_a  : act_a_q;
    use_b  = take_new ? new_b  : act_b_q;

    sw_nx  = (sw_q == '0) ? '0 : sw_q - 1'b1;

    run_d      = run_q;
    sw_d       = sw_q;
    pg_d       = pg_q;
    act_hi_d   = act_hi_q;
    act_a_d    = act_a_q;
    act_b_d    = act_b_q;
    reload     = 1'b0;
    reload_val = '0;

    if (take_new) begin
      act_hi_d = new_hi;
      act_a_d  = new_a;
      act_b_d  = new_b;
    end

    if (start) begin
      run_d      = 1'b1;
      sw_d       = use_a;
      pg_d       = use_b - 1'b1;
      reload     = 1'b1;
      reload_val = seg_last(use_hi, use_a != '0);
    end else if (run_q && seg_end) begin
      sw_d       = sw_nx;
      pg_d       = pg_q - 1'b1;
      reload     = 1'b1;
      reload_val = seg_last(act_hi_q, sw_nx != '0);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      sw_q     <= '0;
      pg_q     <= '0;
      act_hi_q <= 1'b0;
      act_a_q  <= '0;
      act_b_q  <= '0;
    end else begin
      run_q    <= run_d;
      sw_q     <= sw_d;
      pg_q     <= pg_d;
      act_hi_q <= act_hi_d;
      act_a_q  <= act_a_d;
      act_b_q  <= act_b_d;
    end
  end

  assign run   = run_q;
  assign pulse = term;

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_swallow_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (int'(sw_q) <= int'(pg_q) + 1));

  assert_hold_midperiod_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !term) |=> ($stable(act_hi_q) && $stable(act_a_q) && $stable(act_b_q)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !pulse);

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int NW       = 15,
  parameter int LOG_P_LO = 3,
  parameter int LOG_P_HI = 4,
  parameter int N_MIN_LO = 201,
  parameter int N_MAX_LO = 16383,
  parameter int N_MIN_HI = 521,
  parameter int N_MAX_HI = 32767
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic [NW-1:0] n_req,
  output logic          div_out,
  output logic          cfg_err
);

  localparam int AW      = LOG_P_HI;
  localparam int BW      = NW - LOG_P_LO;
  localparam int CW      = LOG_P_HI + 1;
  localparam int CNT_MAX = 1 << LOG_P_HI;

  logic          legal, new_hi, seg_end, run, reload, pulse;
  logic [AW-1:0] new_a;
  logic [BW-1:0] new_b;
  logic [CW-1:0] reload_val;
  logic          err_q, err_d;

  pswallow_ratio #(
    .NW(NW), .LOG_P_LO(LOG_P_LO), .LOG_P_HI(LOG_P_HI),
    .N_MIN_LO(N_MIN_LO), .N_MAX_LO(N_MAX_LO),
    .N_MIN_HI(N_MIN_HI), .N_MAX_HI(N_MAX_HI),
    .AW(AW), .BW(BW)
  ) u_ratio (
    .sel   (sel),
    .n_req (n_req),
    .legal (legal),
    .hi    (new_hi),
    .a_cnt (new_a),
    .b_cnt (new_b)
  );

  pswallow_ctl #(
    .LOG_P_LO(LOG_P_LO), .LOG_P_HI(LOG_P_HI),
    .AW(AW), .BW(BW), .CW(CW)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .legal      (legal),
    .new_hi     (new_hi),
    .new_a      (new_a),
    .new_b      (new_b),
    .seg_end    (seg_end),
    .run        (run),
    .reload     (reload),
    .reload_val (reload_val),
    .pulse      (pulse)
  );

  pswallow_presc #(
    .CW(CW), .CNT_MAX(CNT_MAX)
  ) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (run),
    .reload     (reload),
    .reload_val (reload_val),
    .seg_end    (seg_end)
  );

  // next state of the error flag
  always_comb begin
    err_d = !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign div_out = pulse;
  assign cfg_err = err_q;

  // an output pulse can only come from a divider that was started
  assert_pulse_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> run);

endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;

  localparam int NW     = 15;
  localparam int MIN_LO = 56;
  localparam int MAX_LO = 16383;
  localparam int MIN_HI = 240;
  localparam int MAX_HI = 32767;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sel = 2'b00;
  logic [NW-1:0] n_req = '0;
  logic          div_out;
  logic          cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pswallow_div #(
    .NW(NW), .LOG_P_LO(3), .LOG_P_HI(4),
    .N_MIN_LO(MIN_LO), .N_MAX_LO(MAX_LO),
    .N_MIN_HI(MIN_HI), .N_MAX_HI(MAX_HI)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .n_req   (n_req),
    .div_out (div_out),
    .cfg_err (cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // error flag after one rising edge with the request applied
  task automatic err_after(input logic [1:0] s, input int n, output int e);
    sel   = s;
    n_req = NW'(n);
    @(negedge clk);
    e = int'(cfg_err);
  endtask

  // wait for a pulse, then count cycles to the next one
  task automatic measure(output int cyc, output bit width_ok);
    int guard;
    guard = 0;
    while (!div_out && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    cyc = 0;
    width_ok = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && div_out) width_ok = 1'b0;
    end while (!div_out && cyc < 40000);
  endtask

  task automatic period_check(input logic [1:0] s, input int n, input string req);
    int c;
    bit w;
    sel   = s;
    n_req = NW'(n);
    measure(c, w);
    check(c == n, req, c, n);
    check(w, "R4 width", int'(w), 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int e;
    int c;
    int lows;
    bit w;

    // R8: outputs quiet in reset
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R8 div_out in reset", int'(div_out), 0);
    check(cfg_err == 1'b0, "R8 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;

    // R9: no legal request yet (N=0), no pulse
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (div_out) lows++;
    end
    check(lows == 0, "R9 idle pulses", lows, 0);
    check(cfg_err == 1'b1, "R2 N=0 flagged", int'(cfg_err), 1);

    // R2 window edges, modulus 8
    err_after(2'b00, MIN_LO - 1, e); check(e == 1, "R2 below min", e, 1);
    err_after(2'b01, MIN_LO,     e); check(e == 0, "R2 at min",    e, 0);
    err_after(2'b00, MAX_LO,     e); check(e == 0, "R2 at max",    e, 0);
    err_after(2'b01, MAX_LO + 1, e); check(e == 1, "R2 above max", e, 1);
    // R3 window edges, modulus 16
    err_after(2'b10, MIN_HI - 1, e); check(e == 1, "R3 below min", e, 1);
    err_after(2'b11, MIN_HI,     e); check(e == 0, "R3 at min",    e, 0);
    err_after(2'b10, MAX_HI,     e); check(e == 0, "R3 at max",    e, 0);
    // R1: the same N judged per modulus
    err_after(2'b11, 100, e); check(e == 1, "R1 code 11 uses 16", e, 1);
    err_after(2'b01, 100, e); check(e == 0, "R1 code 01 uses 8",  e, 0);

    do_reset();

    // R4/R5/R1: every residue, modulus 8, alternating codes
    for (int n = MIN_LO; n < MIN_LO + 64; n++)
      period_check((n % 2 == 1) ? 2'b01 : 2'b00, n, "R5 period P=8");
    // R4/R5/R1: every residue, modulus 16
    for (int n = MIN_HI; n < MIN_HI + 64; n++)
      period_check((n % 2 == 1) ? 2'b11 : 2'b10, n, "R5 period P=16");

    // R6: illegal requests keep the last legal ratio
    period_check(2'b00, 100, "R6 base period");
    sel = 2'b00; n_req = NW'(20);
    @(negedge clk);
    check(cfg_err == 1'b1, "R6 flag", int'(cfg_err), 1);
    measure(c, w); check(c == 100, "R6 held ratio", c, 100);
    sel = 2'b10; n_req = NW'(100);
    measure(c, w); check(c == 100, "R6 held across modulus", c, 100);

    // R7: mid-period change lands at period end
    sel = 2'b00; n_req = NW'(100);
    measure(c, w);
    c = 0;
    do begin
      @(negedge clk);
      c++;
      if (c == 10) begin
        sel = 2'b10; n_req = NW'(300);
      end
    end while (!div_out && c < 40000);
    check(c == 100, "R7 current period kept", c, 100);
    measure(c, w); check(c == 300, "R7 new ratio next", c, 300);

    // R2: full period at the top of the modulus-8 window
    period_check(2'b01, MAX_LO, "R2 max period");

    finish_run();
  end

endmodule